// File: doc/BRIEF.md
# DMA Request Handshake FIFO Port

This block sits between an external DMA controller and two small word FIFOs. One FIFO carries received words out to the bus. The other carries words from the bus toward the transmit logic. For each direction there is a request/acknowledge pair.

The receive request stays high while received words are waiting. The transmit request stays high while the transmit FIFO has a free slot. While an acknowledge is held low, a bus strobe in the matching direction goes straight to its FIFO, whatever the address and chip select show. Without an acknowledge, the same FIFOs can still be reached by an ordinary decoded access at two fixed addresses.

A bus access starts at the first clock edge where its strobe is seen high. The FIFO acts once, at that edge, however long the strobe is held. As a result, a request falls at the start of the access that empties or fills its FIFO, not at the end.

On the internal side, the receive FIFO has a push port and the transmit FIFO has a show-ahead pop port. Each port has a ready signal for flow control.

Top module: `dma_fifo_port`

## Requirements
- R1: After reset, `rx_req` is 0, `tx_req` is 1, `rx_push_ready` is 1, `tx_pop_ready` is 0, and both sticky flags are 0.
- R2: `rx_req` is 1 exactly while the receive FIFO holds at least one word. A push into an empty receive FIFO raises it after that clock edge.
- R3: `rx_req` goes to 0 at the clock edge where the read of the last remaining receive word starts, while the strobe is still held.
- R4: While `rx_ack_n` is 0, a read access pops the receive FIFO for any value of `addr` and `cs_n`.
- R5: With both acknowledges high, a read pops only when `cs_n` is 0 and `addr` equals `RX_ADDR`, and a write pushes only when `cs_n` is 0 and `addr` equals `TX_ADDR`. Any other access changes neither FIFO.
- R6: `tx_req` is 1 exactly while the transmit FIFO has a free slot.
- R7: `tx_req` goes to 0 at the clock edge where the write that fills the last free transmit slot starts.
- R8: While `tx_ack_n` is 0, a write access pushes `bus_wdata` into the transmit FIFO for any value of `addr` and `cs_n`.
- R9: Both FIFOs keep first-in first-out order. `bus_rdata` takes the popped word at the access-start edge and holds it until the next pop.
- R10: A read access to an empty receive FIFO leaves `bus_rdata` unchanged and sets `rx_underrun`, which stays set until reset.
- R11: A write access to a full transmit FIFO is dropped and sets `tx_overrun`, which stays set until reset.
- R12: `rx_push_ready` is 0 when the receive FIFO holds DEPTH words, and a push at that time is ignored. `tx_pop_ready` is 1 while the transmit FIFO is not empty, and `tx_pop_data` shows its oldest word.
- R13: A strobe held high for several cycles counts as one access. Only its rising edge, as seen by the clock, acts on a FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_rd | input | 1 | Bus read strobe, active high |
| bus_wr | input | 1 | Bus write strobe, active high |
| cs_n | input | 1 | Chip select for decoded accesses, active low |
| addr | input | ADDR_W | Word address for decoded accesses |
| bus_wdata | input | WIDTH | Write data from the bus |
| bus_rdata | output | WIDTH | Last word popped from the receive FIFO |
| rx_ack_n | input | 1 | Receive acknowledge, active low |
| tx_ack_n | input | 1 | Transmit acknowledge, active low |
| rx_req | output | 1 | Receive request, active high |
| tx_req | output | 1 | Transmit request, active high |
| rx_push | input | 1 | Internal push into the receive FIFO |
| rx_push_data | input | WIDTH | Word to push |
| rx_push_ready | output | 1 | Receive FIFO can take a word |
| tx_pop | input | 1 | Internal pop from the transmit FIFO |
| tx_pop_data | output | WIDTH | Oldest transmit word (show-ahead) |
| tx_pop_ready | output | 1 | Transmit FIFO holds a word |
| rx_underrun | output | 1 | Sticky: read of empty receive FIFO |
| tx_overrun | output | 1 | Sticky: write to full transmit FIFO |

## Verification
The assertions run on every cycle. They check that each request falls right after the access that empties or fills its FIFO. They also check that both error flags never clear, that an underrun read leaves the read data unchanged, and that a held strobe does not move the receive level again.

The directed scenarios cover what only a full sequence can show:
- word order through both FIFOs;
- acknowledge-steered accesses with a junk address and chip select;
- decoded accesses that miss and have no effect;
- a request observed low while the final strobe is still high;
- words dropped on overrun.

// File: rtl/dma_fifo_port.sv
module dma_fifo_port #(
  parameter int DEPTH   = 8,
  parameter int WIDTH   = 16,
  parameter int ADDR_W  = 6,
  parameter int RX_ADDR = 16,
  parameter int TX_ADDR = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              cs_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic              rx_ack_n,
  input  logic              tx_ack_n,
  output logic              rx_req,
  output logic              tx_req,
  input  logic              rx_push,
  input  logic [WIDTH-1:0]  rx_push_data,
  output logic              rx_push_ready,
  input  logic              tx_pop,
  output logic [WIDTH-1:0]  tx_pop_data,
  output logic              tx_pop_ready,
  output logic              rx_underrun,
  output logic              tx_overrun
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  logic             rd_q, wr_q;
  logic [CNT_W-1:0] rx_cnt, tx_cnt;
  logic [PTR_W-1:0] rx_wp, rx_rp, tx_wp, tx_rp;
  logic [WIDTH-1:0] rx_mem [DEPTH];
  logic [WIDTH-1:0] tx_mem [DEPTH];

  wire rd_start   = bus_rd & ~rd_q;
  wire wr_start   = bus_wr & ~wr_q;
  wire rx_hit     = ~rx_ack_n | (~cs_n & (addr == ADDR_W'(RX_ADDR)));
  wire tx_hit     = ~tx_ack_n | (~cs_n & (addr == ADDR_W'(TX_ADDR)));
  wire rx_pop_evt = rd_start & rx_hit;
  wire tx_psh_evt = wr_start & tx_hit;

  wire rx_empty = (rx_cnt == '0);
  wire rx_full  = (rx_cnt == FULL_CNT);
  wire tx_empty = (tx_cnt == '0);
  wire tx_full  = (tx_cnt == FULL_CNT);

  wire rx_push_ok = rx_push & ~rx_full;
  wire rx_pop_ok  = rx_pop_evt & ~rx_empty;
  wire tx_push_ok = tx_psh_evt & ~tx_full;
  wire tx_pop_ok  = tx_pop & ~tx_empty;

  assign rx_req        = ~rx_empty;
  assign tx_req        = ~tx_full;
  assign rx_push_ready = ~rx_full;
  assign tx_pop_ready  = ~tx_empty;
  assign tx_pop_data   = tx_mem[tx_rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      rd_q <= bus_rd;
      wr_q <= bus_wr;
    end
  end

  always_ff @(posedge clk) begin
    if (rx_push_ok) rx_mem[rx_wp] <= rx_push_data;
    if (tx_push_ok) tx_mem[tx_wp] <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp       <= '0;
      rx_rp       <= '0;
      rx_cnt      <= '0;
      bus_rdata   <= '0;
      rx_underrun <= 1'b0;
    end else begin
      if (rx_push_ok) rx_wp <= ptr_inc(rx_wp);
      if (rx_pop_ok) begin
        rx_rp     <= ptr_inc(rx_rp);
        bus_rdata <= rx_mem[rx_rp];
      end
      if (rx_pop_evt && rx_empty) rx_underrun <= 1'b1;
      case ({rx_push_ok, rx_pop_ok})
        2'b10:   rx_cnt <= rx_cnt + 1'b1;
        2'b01:   rx_cnt <= rx_cnt - 1'b1;
        default: rx_cnt <= rx_cnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp      <= '0;
      tx_rp      <= '0;
      tx_cnt     <= '0;
      tx_overrun <= 1'b0;
    end else begin
      if (tx_push_ok) tx_wp <= ptr_inc(tx_wp);
      if (tx_pop_ok)  tx_rp <= ptr_inc(tx_rp);
      if (tx_psh_evt && tx_full) tx_overrun <= 1'b1;
      case ({tx_push_ok, tx_pop_ok})
        2'b10:   tx_cnt <= tx_cnt + 1'b1;
        2'b01:   tx_cnt <= tx_cnt - 1'b1;
        default: tx_cnt <= tx_cnt;
      endcase
    end
  end

  // R3: the access taking the last receive word drops the request at once
  p_rxreq_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_req && rx_pop_evt && rx_cnt == CNT_W'(1) && !rx_push) |=> !rx_req);

  // R7: the write filling the last slot drops the transmit request at once
  p_txreq_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && tx_psh_evt && tx_cnt == FULL_CNT - 1'b1 && !tx_pop) |=> !tx_req);

  // R2: a push into an empty receive FIFO raises the request
  p_rxreq_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_req && rx_push) |=> rx_req);

  // R10
  p_underrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_underrun |=> rx_underrun);
  p_underrun_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop_evt && !rx_req) |=> $stable(bus_rdata));

  // R11
  p_overrun_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_overrun |=> tx_overrun);

  // R13: a held strobe does not pop again
  p_held_strobe_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && rd_q && !rx_push) |=> $stable(rx_cnt));
endmodule

// File: tb/dma_fifo_port_tb.sv
module dma_fifo_port_tb;
  localparam int DEPTH = 8;
  localparam int W = 16;
  localparam int AW = 6;
  localparam logic [AW-1:0] RXA = 6'h10;
  localparam logic [AW-1:0] TXA = 6'h11;

  logic clk = 0, rst_n = 0;
  logic bus_rd = 0, bus_wr = 0, cs_n = 1;
  logic [AW-1:0] addr = '0;
  logic [W-1:0] bus_wdata = '0, rx_push_data = '0;
  logic rx_ack_n = 1, tx_ack_n = 1, rx_push = 0, tx_pop = 0;
  logic [W-1:0] bus_rdata, tx_pop_data;
  logic rx_req, tx_req, rx_push_ready, tx_pop_ready, rx_underrun, tx_overrun;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dma_fifo_port #(.DEPTH(DEPTH), .WIDTH(W), .ADDR_W(AW), .RX_ADDR(16), .TX_ADDR(17)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .cs_n(cs_n),
    .addr(addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_ack_n(rx_ack_n), .tx_ack_n(tx_ack_n), .rx_req(rx_req), .tx_req(tx_req),
    .rx_push(rx_push), .rx_push_data(rx_push_data), .rx_push_ready(rx_push_ready),
    .tx_pop(tx_pop), .tx_pop_data(tx_pop_data), .tx_pop_ready(tx_pop_ready),
    .rx_underrun(rx_underrun), .tx_overrun(tx_overrun));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // all drives happen at falling edges
  task automatic push_rx(input logic [W-1:0] d);
    rx_push = 1; rx_push_data = d;
    @(negedge clk); rx_push = 0;
  endtask

  // read strobe held HOLD cycles; mid-strobe sample after the start edge
  task automatic bus_read(input logic ack, input logic cs, input logic [AW-1:0] a,
                          input int hold, output logic [W-1:0] d, output logic req_mid);
    rx_ack_n = ~ack; cs_n = ~cs; addr = a; bus_rd = 1;
    @(negedge clk); d = bus_rdata; req_mid = rx_req;
    for (int i = 1; i < hold; i++) @(negedge clk);
    bus_rd = 0; rx_ack_n = 1; cs_n = 1;
    @(negedge clk);
  endtask

  task automatic bus_write(input logic ack, input logic cs, input logic [AW-1:0] a,
                           input logic [W-1:0] d, output logic req_mid);
    tx_ack_n = ~ack; cs_n = ~cs; addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); req_mid = tx_req;
    bus_wr = 0; tx_ack_n = 1; cs_n = 1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 rx_req", rx_req, 0);
    chk("R1 tx_req", tx_req, 1);
    chk("R1 rx_push_ready", rx_push_ready, 1);
    chk("R1 tx_pop_ready", tx_pop_ready, 0);
    chk("R1 flags", {rx_underrun, tx_overrun}, 0);
  endtask

  task automatic t_rx_ack;
    logic [W-1:0] d; logic rq;
    push_rx(16'hA001);
    chk("R2 req after push", rx_req, 1);
    push_rx(16'hA002); push_rx(16'hA003);
    bus_read(1, 0, 6'h3F, 1, d, rq);
    chk("R4 ack read junk addr", d, 16'hA001);
    chk("R9 req stays", rq, 1);
    bus_read(1, 1, 6'h05, 1, d, rq);
    chk("R4 ack read with cs", d, 16'hA002);
    bus_read(1, 0, 6'h00, 3, d, rq);
    chk("R9 last word", d, 16'hA003);
    chk("R3 req low mid-strobe", rq, 0);
  endtask

  task automatic t_rx_decode;
    logic [W-1:0] d; logic rq;
    push_rx(16'hB001); push_rx(16'hB002);
    bus_read(0, 1, TXA, 1, d, rq);
    chk("R5 wrong addr keeps data", d, 16'hA003);
    bus_read(0, 0, RXA, 1, d, rq);
    chk("R5 no cs keeps data", d, 16'hA003);
    bus_read(0, 1, RXA, 1, d, rq);
    chk("R5 decoded read", d, 16'hB001);
    bus_read(0, 1, RXA, 4, d, rq);
    chk("R13 held strobe word", d, 16'hB002);
    chk("R13 req after held", rx_req, 0);
    chk("R13 no underrun", rx_underrun, 0);
  endtask

  task automatic t_underrun;
    logic [W-1:0] d; logic rq;
    bus_read(1, 0, 6'h00, 1, d, rq);
    chk("R10 rdata held", d, 16'hB002);
    chk("R10 flag set", rx_underrun, 1);
    push_rx(16'hC000);
    bus_read(1, 0, 6'h00, 1, d, rq);
    chk("R10 flag sticky", rx_underrun, 1);
    chk("R9 after underrun", d, 16'hC000);
  endtask

  task automatic t_rx_full;
    logic [W-1:0] d; logic rq;
    for (int i = 0; i < DEPTH; i++) push_rx(W'(16'hD000 + i));
    chk("R12 push_ready low", rx_push_ready, 0);
    push_rx(16'hDEAD);
    for (int i = 0; i < DEPTH; i++) begin
      bus_read(1, 0, 6'h00, 1, d, rq);
      chk("R12 R9 full drain order", d, W'(16'hD000 + i));
    end
    chk("R12 ignored push", rx_req, 0);
  endtask

  task automatic t_tx;
    logic rq;
    bus_write(0, 1, RXA, 16'h1111, rq);
    bus_write(0, 0, TXA, 16'h2222, rq);
    chk("R5 missed writes", tx_pop_ready, 0);
    for (int i = 0; i < DEPTH; i++) begin
      bus_write(1, 0, 6'h2A, W'(16'hE000 + i), rq);
      if (i < DEPTH - 1) chk("R6 tx_req with space", rq, 1);
      else chk("R7 req low mid-strobe", rq, 0);
    end
    chk("R12 pop_ready", tx_pop_ready, 1);
    chk("R11 no overrun yet", tx_overrun, 0);
    bus_write(1, 1, TXA, 16'hBAD0, rq);
    chk("R11 overrun flag", tx_overrun, 1);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R8 R9 tx order", tx_pop_data, W'(16'hE000 + i));
      tx_pop = 1; @(negedge clk); tx_pop = 0;
      if (i == 0) chk("R6 req back", tx_req, 1);
    end
    chk("R11 dropped word", tx_pop_ready, 0);
    chk("R11 sticky", tx_overrun, 1);
    bus_write(0, 1, TXA, 16'h3333, rq);
    chk("R5 decoded write", tx_pop_data, 16'h3333);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_rx_ack();
    t_rx_decode();
    t_underrun();
    t_rx_full();
    t_tx();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule